// File: doc/BRIEF.md
# MSI Vector Capture Controller

This block receives message-signalled interrupts at a PCI Express root port. Software programs a 64-bit doorbell address, then sets which of 32 vectors may be captured and which of them may raise the interrupt line. An endpoint signals an interrupt by sending a 32-bit posted write to the doorbell address. The low five bits of the written data name a vector. If that vector is enabled, its bit is set in the pending register.

A single level interrupt output tells the processor that an unmasked vector is pending. The output is evaluated again only when a vector is captured or software writes the pending register. A pending write flips every bit that is written as one. The output drops only when the whole pending register reaches zero. Inbound reads, partial-width writes and writes to other addresses are not claimed. The fabric forwards them as normal traffic.

Top module: `msicap_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `irq` is low and no inbound access is claimed.
- R2: Offset 0x820 holds doorbell address bits 31:0 and offset 0x824 holds bits 63:32. A write to either offset replaces only its own half, and both halves read back.
- R3: An inbound write with byte enables 4'hF is claimed (`in_claim` high in the same cycle) when `in_addr[63:2]` equals doorbell bits 63:2 and the enable register (offset 0x828) is nonzero. At the clock edge the bit selected by `in_data[4:0]` is OR-ed into the pending register (offset 0x830) if that bit is set in the enable register.
- R4: A claimed write that selects a vector whose enable bit is clear leaves the pending register unchanged.
- R5: While the enable register is zero, a write to the doorbell is not claimed and changes nothing.
- R6: Inbound reads, writes with any byte enable clear, and writes whose address lies outside the 4-byte doorbell window are not claimed and change nothing.
- R7: After a capture, `irq` is high from the next clock edge if pending AND NOT mask (mask at offset 0x82C) is nonzero. A capture never lowers `irq`.
- R8: A register write to offset 0x830 XORs the written value into the pending register. `irq` falls only when the result is zero, and such a write never raises `irq`.
- R9: A write to the mask register does not change `irq`. A masked or unmasked state takes effect only at the next capture or pending write.
- R10: Data bits 31:5 of an inbound write have no effect on which vector is selected.
- R11: The enable, mask and pending registers read back what was stored. Other offsets read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| in_valid | input | 1 | Inbound request valid |
| in_write | input | 1 | Inbound request is a write (0 = read) |
| in_be | input | 4 | Inbound byte enables |
| in_addr | input | 64 | Inbound byte address |
| in_data | input | 32 | Inbound write data (vector index in bits 4:0) |
| in_claim | output | 1 | Request is absorbed as an interrupt message |
| irq | output | 1 | Level interrupt to the processor |

## Verification
A sweep sends all 32 vector indices against a checkerboard enable pattern, with junk in the upper data bits. This shows that the index decodes correctly, that disabled vectors are gated and that the upper data bits are ignored. A second pass uses a fully set mask and then clears the mask in the middle of the run. It shows whether `irq` follows the pending state at once or, as required, only at the next capture or pending write. Pending writes that clear part of the register, all of it, or set a bit from zero tell XOR updates apart from write-one-to-clear updates, and separate "falls at zero" from "tracks the unmasked bits". Inbound reads, partial-width writes, neighbouring words, a different upper address half and an all-zero enable each probe one condition of the claim decode.

// File: rtl/msicap_pkg.sv
// Package: register offsets and the select type shared by the MSI capture
// controller. Assumes byte offsets on a 12-bit register window, 32-bit access.
package msicap_pkg;

    localparam int unsigned CFG_AW = 12;

    localparam logic [CFG_AW-1:0] OFS_DOORBELL_LO = 12'h820;
    localparam logic [CFG_AW-1:0] OFS_DOORBELL_HI = 12'h824;
    localparam logic [CFG_AW-1:0] OFS_VEC_ENABLE  = 12'h828;
    localparam logic [CFG_AW-1:0] OFS_VEC_MASK    = 12'h82C;
    localparam logic [CFG_AW-1:0] OFS_PENDING     = 12'h830;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DB_LO,
        SEL_DB_HI,
        SEL_ENABLE,
        SEL_MASK,
        SEL_PENDING
    } reg_sel_e;

    // Map a register byte offset to the register it selects.
    function automatic reg_sel_e decode_offset(input logic [CFG_AW-1:0] ofs);
        case (ofs)
            OFS_DOORBELL_LO: return SEL_DB_LO;
            OFS_DOORBELL_HI: return SEL_DB_HI;
            OFS_VEC_ENABLE:  return SEL_ENABLE;
            OFS_VEC_MASK:    return SEL_MASK;
            OFS_PENDING:     return SEL_PENDING;
            default:         return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/msicap_regs.sv
// Module: configuration storage of the MSI capture controller: the doorbell
// address in two halves, the vector enable and the vector mask.
// Assumes one register write per cycle, already decoded to a select.
module msicap_regs
    import msicap_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  reg_sel_e            wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [2*DATA_W-1:0] doorbell,
    output logic [DATA_W-1:0]   vec_enable,
    output logic [DATA_W-1:0]   vec_mask
);

    localparam int unsigned HALVES = 2;

    // One register per doorbell half; each half only takes its own write.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        localparam reg_sel_e HALF_SEL = (h == 0) ? SEL_DB_LO : SEL_DB_HI;
        logic [DATA_W-1:0] half_q;

        // Capture the write aimed at this half.
        always_ff @(posedge clk) begin
            if (!rst_n)                              half_q <= '0;
            else if (wr_en && wr_sel == HALF_SEL)    half_q <= wr_data;
        end

        assign doorbell[h*DATA_W +: DATA_W] = half_q;
    end

    // Vector enable and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_enable <= '0;
            vec_mask   <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_ENABLE) vec_enable <= wr_data;
            if (wr_sel == SEL_MASK)   vec_mask   <= wr_data;
        end
    end

    // R2: writing one half leaves the other half as it was.
    a_r2_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_DB_LO) |=> $stable(doorbell[2*DATA_W-1:DATA_W]));
    a_r2_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_DB_HI) |=> $stable(doorbell[DATA_W-1:0]));

endmodule

// File: rtl/msicap_match.sv
// Module: decides whether an inbound request is an interrupt message and
// turns its vector index into a one-hot bit. Purely combinational.
// Assumes the doorbell window is one aligned word.
module msicap_match #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = $clog2(DATA_W),
    parameter int unsigned BE_W   = DATA_W / 8
) (
    input  logic                in_valid,
    input  logic                in_write,
    input  logic [BE_W-1:0]     in_be,
    input  logic [2*DATA_W-1:0] in_addr,
    input  logic [IDX_W-1:0]    in_index,
    input  logic [2*DATA_W-1:0] doorbell,
    input  logic [DATA_W-1:0]   vec_enable,
    output logic                hit,
    output logic [DATA_W-1:0]   vec_onehot
);

    localparam int unsigned WORD_LSB = $clog2(BE_W);

    logic addr_match;
    logic full_word;
    logic window_live;

    // Qualify the request: aligned word match, full width, window enabled.
    always_comb begin
        addr_match  = (in_addr[2*DATA_W-1:WORD_LSB] == doorbell[2*DATA_W-1:WORD_LSB]);
        full_word   = &in_be;
        window_live = |vec_enable;
        hit         = in_valid && in_write && full_word && addr_match && window_live;
    end

    // One-hot vector selected by the index bits.
    always_comb begin
        vec_onehot = {{(DATA_W-1){1'b0}}, 1'b1} << in_index;
    end

endmodule

// File: rtl/msicap_status.sv
// Module: pending register and interrupt line. Captures gate on the enable,
// software writes flip bits, and the line is re-evaluated only on those two
// events. Assumes a capture and a pending write may coincide; the write is
// applied first.
module msicap_status #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_valid,
    input  logic [DATA_W-1:0] cap_onehot,
    input  logic [DATA_W-1:0] vec_enable,
    input  logic [DATA_W-1:0] vec_mask,
    input  logic              pend_wr,
    input  logic [DATA_W-1:0] pend_wdata,
    output logic [DATA_W-1:0] pending,
    output logic              irq
);

    logic [DATA_W-1:0] after_wr;
    logic [DATA_W-1:0] pend_next;
    logic              irq_next;

    // Next pending value: flip by the write, then OR in the gated capture.
    always_comb begin
        after_wr  = pend_wr ? (pending ^ pend_wdata) : pending;
        pend_next = after_wr | (cap_valid ? (cap_onehot & vec_enable) : '0);
    end

    // Next interrupt level: raise on an unmasked capture, drop at all-zero.
    always_comb begin
        irq_next = irq;
        if (cap_valid && |(pend_next & ~vec_mask)) irq_next = 1'b1;
        else if (pend_wr && pend_next == '0)       irq_next = 1'b0;
    end

    // Pending and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            irq     <= 1'b0;
        end else begin
            pending <= pend_next;
            irq     <= irq_next;
        end
    end

    // R3: an enabled vector that is captured is pending at the next edge.
    a_r3_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !pend_wr) |=>
        ((pending & $past(cap_onehot & vec_enable)) == $past(cap_onehot & vec_enable)));

    // R4: without a software write, no bit outside the enable becomes pending.
    a_r4_no_disabled_set: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_wr |=> ((pending & ~$past(pending) & ~$past(vec_enable)) == '0));

    // R7: the line rises only in the cycle after a capture.
    a_r7_rise_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cap_valid));

    // R8: the line falls only with an empty pending register.
    a_r8_fall_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> (pending == '0));

endmodule

// File: rtl/msicap_top.sv
// Module: MSI capture controller top. Decodes register accesses, returns
// read data combinationally, and connects the doorbell match to the pending
// and interrupt logic. Assumes 32-bit register accesses and a 64-bit inbound
// address; unmatched inbound traffic is left for the fabric to forward.
module msicap_top
    import msicap_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [11:0]         cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [DATA_W-1:0]   cfg_rdata,
    input  logic                in_valid,
    input  logic                in_write,
    input  logic [DATA_W/8-1:0] in_be,
    input  logic [2*DATA_W-1:0] in_addr,
    input  logic [DATA_W-1:0]   in_data,
    output logic                in_claim,
    output logic                irq
);

    localparam int unsigned IDX_W = $clog2(DATA_W);
    localparam int unsigned BE_W  = DATA_W / 8;

    reg_sel_e            sel;
    logic [2*DATA_W-1:0] doorbell;
    logic [DATA_W-1:0]   vec_enable;
    logic [DATA_W-1:0]   vec_mask;
    logic [DATA_W-1:0]   pending;
    logic [DATA_W-1:0]   vec_onehot;
    logic                pend_wr;
    logic                unused_data_hi;

    // Register select from the byte offset.
    always_comb begin
        sel     = decode_offset(cfg_addr);
        pend_wr = cfg_wr && sel == SEL_PENDING;
    end

    // Upper inbound data bits carry no meaning for vector selection.
    assign unused_data_hi = ^in_data[DATA_W-1:IDX_W];

    msicap_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr),
        .wr_sel     (sel),
        .wr_data    (cfg_wdata),
        .doorbell   (doorbell),
        .vec_enable (vec_enable),
        .vec_mask   (vec_mask)
    );

    msicap_match #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BE_W(BE_W)) u_match (
        .in_valid   (in_valid),
        .in_write   (in_write),
        .in_be      (in_be),
        .in_addr    (in_addr),
        .in_index   (in_data[IDX_W-1:0]),
        .doorbell   (doorbell),
        .vec_enable (vec_enable),
        .hit        (in_claim),
        .vec_onehot (vec_onehot)
    );

    msicap_status #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_valid  (in_claim),
        .cap_onehot (vec_onehot),
        .vec_enable (vec_enable),
        .vec_mask   (vec_mask),
        .pend_wr    (pend_wr),
        .pend_wdata (cfg_wdata),
        .pending    (pending),
        .irq        (irq)
    );

    // Read data multiplexer; unmapped offsets read zero.
    always_comb begin
        case (sel)
            SEL_DB_LO:   cfg_rdata = doorbell[DATA_W-1:0];
            SEL_DB_HI:   cfg_rdata = doorbell[2*DATA_W-1:DATA_W];
            SEL_ENABLE:  cfg_rdata = vec_enable;
            SEL_MASK:    cfg_rdata = vec_mask;
            SEL_PENDING: cfg_rdata = pending;
            default:     cfg_rdata = '0;
        endcase
    end

    // R9: a mask write with no coinciding capture leaves the line alone.
    a_r9_mask_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && sel == SEL_MASK && !in_claim) |=> $stable(irq));

    // R5: nothing is claimed while the enable register is zero.
    a_r5_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_enable == '0) |-> !in_claim);

endmodule

// File: tb/msicap_top_bench.sv
// Bench: sweeps every vector index against a fixed enable pattern, then
// probes mask, pending-write and claim-decode corners against a model
// computed from the requirements.
module msicap_top_bench;

    localparam logic [11:0] A_LO  = 12'h820;
    localparam logic [11:0] A_HI  = 12'h824;
    localparam logic [11:0] A_EN  = 12'h828;
    localparam logic [11:0] A_MSK = 12'h82C;
    localparam logic [11:0] A_PND = 12'h830;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic        in_write = 1'b0;
    logic [3:0]  in_be = '0;
    logic [63:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic        in_claim;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] m_db = '0;
    logic [31:0] m_en = '0;
    logic [31:0] m_msk = '0;
    logic [31:0] m_pnd = '0;
    logic        m_irq = 1'b0;

    always #10 clk = ~clk;

    msicap_top u_msicap_top (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
        .in_write(in_write), .in_be(in_be), .in_addr(in_addr),
        .in_data(in_data), .in_claim(in_claim), .irq(irq)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic read_chk(input logic [11:0] ofs, input logic [31:0] exp, input string req);
        cfg_addr = ofs;
        #1;
        check(cfg_rdata, exp, req);
    endtask

    // Register write; model follows the requirements.
    task automatic reg_write(input logic [11:0] ofs, input logic [31:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = ofs; cfg_wdata = val;
        @(posedge clk);
        case (ofs)
            A_LO:  m_db[31:0]  = val;
            A_HI:  m_db[63:32] = val;
            A_EN:  m_en = val;
            A_MSK: m_msk = val;
            A_PND: begin
                m_pnd = m_pnd ^ val;
                if (m_pnd == 0) m_irq = 1'b0;
            end
            default: ;
        endcase
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Inbound request; checks claim mid-cycle, then pending and irq after.
    task automatic inbound(input logic wr, input logic [3:0] be, input logic [63:0] a,
                           input logic [31:0] d, input logic exp_claim, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_write = wr; in_be = be; in_addr = a; in_data = d;
        #5;
        check(in_claim, exp_claim, req);
        @(posedge clk);
        if (exp_claim) begin
            m_pnd = m_pnd | ((32'h1 << d[4:0]) & m_en);
            if ((m_pnd & ~m_msk) != 0) m_irq = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0; in_write = 1'b0; in_be = '0;
        read_chk(A_PND, m_pnd, req);
        check(irq, m_irq, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        read_chk(A_LO, 0, "R1"); read_chk(A_HI, 0, "R1");
        read_chk(A_EN, 0, "R1"); read_chk(A_MSK, 0, "R1");
        read_chk(A_PND, 0, "R1");
        check(irq, 0, "R1");
        check(in_claim, 0, "R1");

        // R2: halves of the doorbell
        reg_write(A_LO, 32'hFEE0_1000);
        read_chk(A_LO, 32'hFEE0_1000, "R2"); read_chk(A_HI, 0, "R2");
        reg_write(A_HI, 32'h0000_0003);
        read_chk(A_LO, 32'hFEE0_1000, "R2"); read_chk(A_HI, 32'h3, "R2");
        reg_write(A_LO, 32'hFEE0_2000);
        read_chk(A_HI, 32'h3, "R2"); read_chk(A_LO, 32'hFEE0_2000, "R2");

        // R5: enable zero -> not claimed
        inbound(1'b1, 4'hF, m_db, 32'd4, 1'b0, "R5");

        // R11: enable readback
        reg_write(A_EN, 32'hA5A5_5A5A);
        read_chk(A_EN, 32'hA5A5_5A5A, "R11");

        // R3 R4 R7 R10: sweep every vector, junk in upper data bits
        for (int v = 0; v < 32; v++) begin
            inbound(1'b1, 4'hF, m_db, {27'(v * 32'h0123_4567), 5'(v)}, 1'b1,
                    ((32'hA5A5_5A5A >> v) & 1) != 0 ? "R3/R10" : "R4/R10");
        end
        check(irq, 1, "R7");

        // R8: XOR clear partial keeps irq, full clear drops it
        reg_write(A_PND, 32'hA5A5_0000);
        read_chk(A_PND, 32'h0000_5A5A, "R8"); check(irq, 1, "R8");
        reg_write(A_PND, 32'h0000_5A5A);
        read_chk(A_PND, 0, "R8"); check(irq, 0, "R8");
        reg_write(A_PND, 32'h0000_0001);
        read_chk(A_PND, 1, "R8"); check(irq, 0, "R8");
        reg_write(A_PND, 32'h0000_0001);
        read_chk(A_PND, 0, "R8");

        // R9: mask interplay
        reg_write(A_MSK, 32'hFFFF_FFFF);
        read_chk(A_MSK, 32'hFFFF_FFFF, "R11");
        inbound(1'b1, 4'hF, m_db, 32'd1, 1'b1, "R7");
        check(irq, 0, "R7");
        reg_write(A_MSK, 32'h0);
        check(irq, 0, "R9");
        inbound(1'b1, 4'hF, m_db, 32'd3, 1'b1, "R9");
        check(irq, 1, "R9");
        reg_write(A_MSK, 32'hFFFF_FFFF);
        check(irq, 1, "R9");

        // R6: non-claimed traffic
        inbound(1'b0, 4'hF, m_db, 32'd6, 1'b0, "R6");
        inbound(1'b1, 4'h7, m_db, 32'd6, 1'b0, "R6");
        inbound(1'b1, 4'hF, m_db + 64'd4, 32'd6, 1'b0, "R6");
        inbound(1'b1, 4'hF, m_db ^ 64'h1_0000_0000, 32'd6, 1'b0, "R6");
        inbound(1'b1, 4'hF, m_db - 64'd4, 32'd6, 1'b0, "R6");

        // R11: unmapped offset
        reg_write(12'h834, 32'hFFFF_FFFF);
        read_chk(12'h834, 0, "R11");
        read_chk(A_EN, 32'hA5A5_5A5A, "R11");
        read_chk(A_MSK, 32'hFFFF_FFFF, "R11");
        read_chk(A_PND, m_pnd, "R11");
        read_chk(A_LO, 32'hFEE0_2000, "R11");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule